// File: doc/BRIEF.md
# Nonvolatile Command Sequence Detector

This block sits beside a byte-wide memory and watches its access stream for a fixed series of six reads. Each chip-enable strobe that reaches the block is one access and one candidate step. It carries a write flag and a 13-bit address. Five fixed prefix addresses, read in order, arm the detector. A sixth read then picks the command: one address asks for a copy of the working memory into nonvolatile storage (store), and another asks for the reverse copy (recall). The request leaves the block as a single-cycle pulse for the transfer engine.

The match is strict. Any write aborts it, and so does any read off the expected address. An aborting read of the first prefix address starts a new attempt at once. The transfer engine raises a busy input while it works, and the detector ignores the access stream for that time. A supply-low flag blocks store requests. It does not block recall requests.

Top module: `cmd_seq_detect`

## Requirements
- R1: After reset is released, both request outputs are low and the detector is idle, so the next step it expects is the first prefix address 0x0000.
- R2: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, in that order, raise store_req_o for exactly one cycle. That cycle is the clock cycle after the edge that samples the sixth access.
- R3: The same five-read prefix followed by a read of 0x0F0E raises recall_req_o for exactly one cycle, with the same timing as R2.
- R4: A write access (acc_write_i = 1) at any step, to any address, returns the detector to idle. No request follows unless the full six-read series is repeated.
- R5: A read whose address is not the one expected at the current step aborts the series and no request is issued. A sixth address other than 0x0F0F or 0x0F0E also aborts.
- R6: When the aborting read is of address 0x0000, it counts as the first step of a new series.
- R7: An access presented while busy_i is high has no effect. It neither advances nor aborts a series in progress.
- R8: If supply_low_i is high when the sixth access of a store series is sampled, no store request is issued and the detector returns to idle. Recall requests do not depend on supply_low_i.
- R9: Cycles with acc_valid_i low leave the detector state unchanged, so idle gaps between steps are allowed.
- R10: store_req_o and recall_req_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | One-cycle strobe per chip-enable access |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| acc_addr_i | input | 13 | Access address |
| busy_i | input | 1 | Transfer engine busy; accesses are ignored while high |
| supply_low_i | input | 1 | Supply below the switch threshold; blocks store requests |
| store_req_o | output | 1 | One-cycle store request pulse |
| recall_req_o | output | 1 | One-cycle recall request pulse |

## Verification
The bench goes after aborts at every step, by writes and by wrong reads. A design that only clears on a mismatch at step 0, or that lets a write to a matching address advance, would issue a request the bench does not expect. An abort by a read of 0x0000 must restart the series at step 1; a detector that simply clears would miss the following five-step completion. Accesses under busy, store under supply-low (with recall still going through), and idle gaps inside a series are each checked, where a wrong design either drops or stretches a pulse. A long biased-random stream then compares both outputs cycle by cycle against a reference model built from the requirements.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  localparam int ADDR_W   = 13;
  localparam int N_PREFIX = 5;
  localparam int STEP_W   = $clog2(N_PREFIX + 1);

  localparam logic [ADDR_W-1:0] STORE_KEY  = 13'h0F0F;
  localparam logic [ADDR_W-1:0] RECALL_KEY = 13'h0F0E;

  // ordered prefix; order is behaviour
  function automatic logic [ADDR_W-1:0] prefix_key(input int idx);
    case (idx)
      0:       prefix_key = 13'h0000;
      1:       prefix_key = 13'h1555;
      2:       prefix_key = 13'h0AAA;
      3:       prefix_key = 13'h1FFF;
      default: prefix_key = 13'h10F0;
    endcase
  endfunction
endpackage

// File: rtl/cmd_seq_key_match.sv
module cmd_seq_key_match
  import cmd_seq_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              step_hit_o,
  output logic              first_hit_o,
  output logic              final_o,
  output logic              store_hit_o,
  output logic              recall_hit_o
);
  logic [N_PREFIX-1:0] key_hit;

  for (genvar g = 0; g < N_PREFIX; g++) begin : g_key
    assign key_hit[g] = (addr_i == prefix_key(g));
  end

  always_comb begin
    step_hit_o = 1'b0;
    for (int i = 0; i < N_PREFIX; i++) begin
      if (step_i == STEP_W'(i)) step_hit_o = key_hit[i];
    end
  end

  assign first_hit_o  = key_hit[0];
  assign final_o      = (step_i == STEP_W'(N_PREFIX));
  assign store_hit_o  = (addr_i == STORE_KEY);
  assign recall_hit_o = (addr_i == RECALL_KEY);
endmodule

// File: rtl/cmd_seq_tracker.sv
module cmd_seq_tracker
  import cmd_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic              busy_i,
  input  logic              step_hit_i,
  input  logic              first_hit_i,
  input  logic              final_i,
  input  logic              store_hit_i,
  input  logic              recall_hit_i,
  output logic [STEP_W-1:0] step_o,
  output logic              store_fire_o,
  output logic              recall_fire_o
);
  logic [STEP_W-1:0] step_q, step_d;
  logic              take;

  assign take = acc_valid_i && !busy_i;

  always_comb begin
    step_d        = step_q;
    store_fire_o  = 1'b0;
    recall_fire_o = 1'b0;
    if (take) begin
      if (acc_write_i) begin
        step_d = '0;
      end else if (final_i) begin
        store_fire_o  = store_hit_i;
        recall_fire_o = recall_hit_i;
        step_d        = first_hit_i ? STEP_W'(1) : '0;
      end else if (step_hit_i) begin
        step_d = step_q + STEP_W'(1);
      end else begin
        // a misplaced read of the first key restarts
        step_d = first_hit_i ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  assign step_o = step_q;

  a_r7_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(step_q));
  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> $stable(step_q));
  a_r4_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && !busy_i) |=> (step_q == '0));
  a_r5_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= STEP_W'(N_PREFIX));
endmodule

// File: rtl/cmd_seq_detect.sv
module cmd_seq_detect
  import cmd_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              busy_i,
  input  logic              supply_low_i,
  output logic              store_req_o,
  output logic              recall_req_o
);
  logic [STEP_W-1:0] step;
  logic step_hit, first_hit, final_step, store_hit, recall_hit;
  logic store_fire, recall_fire;

  cmd_seq_key_match u_match (
    .step_i       (step),
    .addr_i       (acc_addr_i),
    .step_hit_o   (step_hit),
    .first_hit_o  (first_hit),
    .final_o      (final_step),
    .store_hit_o  (store_hit),
    .recall_hit_o (recall_hit)
  );

  cmd_seq_tracker u_track (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .acc_valid_i   (acc_valid_i),
    .acc_write_i   (acc_write_i),
    .busy_i        (busy_i),
    .step_hit_i    (step_hit),
    .first_hit_i   (first_hit),
    .final_i       (final_step),
    .store_hit_i   (store_hit),
    .recall_hit_i  (recall_hit),
    .step_o        (step),
    .store_fire_o  (store_fire),
    .recall_fire_o (recall_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_req_o  <= 1'b0;
      recall_req_o <= 1'b0;
    end else begin
      store_req_o  <= store_fire && !supply_low_i;
      recall_req_o <= recall_fire;
    end
  end

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_req_o && recall_req_o));
  a_r2_store_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |=> !store_req_o);
  a_r3_recall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |=> !recall_req_o);
  a_r8_low_blocks_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && supply_low_i) |=> !store_req_o);
  a_r2_from_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_req_o || recall_req_o) |-> $past(acc_valid_i && !busy_i && !acc_write_i));
endmodule

// File: tb/cmd_seq_detect_tb.sv
module cmd_seq_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0, busy = 1'b0, low = 1'b0;
  logic [12:0] addr = '0;
  logic        st, rc;

  int checks = 0, errors = 0;
  int m_step = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_seq_detect dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_write_i(wr),
    .acc_addr_i(addr), .busy_i(busy), .supply_low_i(low),
    .store_req_o(st), .recall_req_o(rc)
  );

  function automatic logic [12:0] key(int i);
    case (i)
      0: key = 13'h0000; 1: key = 13'h1555; 2: key = 13'h0AAA;
      3: key = 13'h1FFF; default: key = 13'h10F0;
    endcase
  endfunction

  // reference model from the requirements; returns {store,recall}
  function automatic logic [1:0] model(bit w, logic [12:0] a, bit b, bit l);
    logic [1:0] r = 2'b00;
    if (b) return r;
    if (w) begin m_step = 0; return r; end
    if (m_step == 5) begin
      if (a == 13'h0F0F && !l) r = 2'b10;
      if (a == 13'h0F0E)       r = 2'b01;
      m_step = (a == 13'h0000) ? 1 : 0;
    end else if (a == key(m_step)) begin
      m_step++;
    end else begin
      m_step = (a == 13'h0000) ? 1 : 0;
    end
    return r;
  endfunction

  task automatic check(string req, logic [1:0] exp);
    checks++;
    if ({st, rc} !== exp) begin
      errors++;
      $display("FAIL %s: got store/recall=%b expected %b", req, {st, rc}, exp);
    end
  endtask

  // we sit at a negedge on entry and on exit
  task automatic acc(string req, bit w, logic [12:0] a, bit b = 0, bit l = 0);
    logic [1:0] e;
    valid = 1'b1; wr = w; addr = a; busy = b; low = l;
    e = model(w, a, b, l);
    @(negedge clk);
    valid = 1'b0; wr = 1'b0; busy = 1'b0; low = 1'b0;
    check(req, e);
  endtask

  task automatic prefix(string req, int n);
    for (int i = 0; i < n; i++) acc(req, 0, key(i));
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); check(req, 2'b00); end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", 2'b00);

    prefix("R2", 5); acc("R2 store", 0, 13'h0F0F);
    idle("R2 single pulse", 1);
    prefix("R3", 5); acc("R3 recall", 0, 13'h0F0E);
    idle("R3 single pulse", 1);

    for (int s = 0; s < 6; s++) begin
      prefix("R4", s); acc("R4 write abort", 1, (s < 5) ? key(s) : 13'h0F0F);
      if (s > 0) prefix("R4 resume", 5 - s + 0);
      acc("R4 no request", 0, 13'h0F0F);
    end

    prefix("R5", 3); acc("R5 wrong read", 0, 13'h0123);
    prefix("R5 tail", 0); acc("R5", 0, key(3)); acc("R5", 0, key(4));
    acc("R5 no request", 0, 13'h0F0F);
    prefix("R5 bad final", 5); acc("R5 bad final", 0, 13'h0F0D);

    prefix("R6", 4); acc("R6 restart", 0, 13'h0000);
    for (int i = 1; i < 5; i++) acc("R6", 0, key(i));
    acc("R6 store after restart", 0, 13'h0F0F);

    prefix("R7", 2); acc("R7 busy write", 1, 13'h1234, 1);
    acc("R7 busy read", 0, 13'h0F0F, 1);
    for (int i = 2; i < 5; i++) acc("R7", 0, key(i));
    acc("R7 recall despite busy noise", 0, 13'h0F0E);

    prefix("R8", 5); acc("R8 store blocked", 0, 13'h0F0F, 0, 1);
    acc("R8 idle after block", 0, 13'h0F0F);
    prefix("R8", 5); acc("R8 recall under low", 0, 13'h0F0E, 0, 1);

    for (int i = 0; i < 5; i++) begin acc("R9", 0, key(i)); idle("R9 gap", 3); end
    acc("R9 store after gaps", 0, 13'h0F0F);

    // biased random stream, R10 and R2/R3 against the model
    for (int n = 0; n < 4000; n++) begin
      int p = $urandom_range(99);
      bit w = ($urandom_range(99) < 5);
      bit b = ($urandom_range(99) < 8);
      bit l = ($urandom_range(99) < 20);
      logic [12:0] a;
      if (p < 70)      a = (m_step == 5) ? ($urandom_range(1) ? 13'h0F0F : 13'h0F0E) : key(m_step);
      else if (p < 80) a = 13'h0000;
      else             a = 13'($urandom);
      acc("R10 random", w, a, b, l);
      if ($urandom_range(9) == 0) idle("R9 random gap", 1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule